// File: doc/BRIEF.md
# Core Idle-State Sequencer with Residency-Based Demotion

This block controls the idle behaviour of one processor core. Each hardware thread of the core states which idle level it wants: keep running, a shallow halt, a clock-stop level in which the private caches are first written back to the shared cache, or a power-off level in which the architectural state is first saved to a dedicated store. The block merges these per-thread wishes into one core target, the shallowest level any thread asks for. It then runs the entry sequence for that level and holds the core there until a wake event arrives. On wake it runs the matching exit sequence.

The cache flush engine, the clock gate, the state save/restore engine and the power switch are outside the block. Each is reached through a request/acknowledge pair. A configuration word can enable automatic demotion of deep requests. The block keeps its own residency history, which is the length of the most recent idle visit. When that visit was shorter than a programmable threshold, a deep request is turned into a shallower one.

Top module: `idle_seq_ctrl`

## Requirements
- R1: After a synchronous reset the core is active: `cstate_o` is 0, `busy_o` is 0, and every handshake request, `clk_stop_o`, `pwr_cut_o` and `snoop_ack_o` are low.
- R2: Thread i requests through bits [2i+1:2i] of `thr_req_i`, coded 0 = run, 1 = halt, 2 = clock-stop, 3 = power-off. The core target is the smallest code among all threads, so one running thread keeps the core active. `cstate_o` reports the resident level with the same coding, and 0 during any transition.
- R3: A halt target enters the halt level on the next clock with no handshake. A wake pulse returns the core to active on the following clock.
- R4: In the halt level a snoop is acknowledged on `snoop_ack_o` one cycle later and the level is kept. In the clock-stop and power-off levels a snoop gets no acknowledge and does not wake the core.
- R5: Clock-stop entry holds `flush_req_o` until `flush_done_i`, then raises `clk_stop_o`, and becomes resident once `clk_stopped_i` is seen high. `clk_stop_o` never rises before the flush has completed.
- R6: A wake in the clock-stop level drops `clk_stop_o`; the core is active once `clk_stopped_i` reads low.
- R7: Power-off entry holds `save_req_o` until `save_done_i`, then raises `pwr_cut_o`, and becomes resident once `pwr_is_off_i` is high. Power is never cut before the save has completed.
- R8: A wake in the power-off level drops `pwr_cut_o`. After `pwr_is_off_i` reads low, the block holds `restore_req_o` until `restore_done_i` and then returns to active.
- R9: A wake during an entry sequence lets the current handshake finish and then unwinds in reverse. After an aborted flush the clocks are never stopped. After an aborted power cut, power is restored and the state reloaded without the core becoming resident.
- R10: The residency history is the number of cycles the core spent resident (halt, clock-stop or power-off) in its last idle visit. It saturates at 2^RES_W-1, which is also its reset value.
- R11: With configuration bit 0 set and history below the threshold, a power-off target becomes clock-stop.
- R12: With configuration bit 1 set and history below the threshold, a clock-stop or power-off target becomes halt. This rule takes priority over R11.
- R13: The configuration word (bit 0 and bit 1 as enables, bits [RES_W+1:2] as threshold) is cleared by reset, so demotion is off until `cfg_we_i` loads a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core-domain clock |
| rst_i | input | 1 | Synchronous active-high reset |
| thr_req_i | input | 2*NUM_THREADS | Per-thread idle level requests |
| wake_i | input | 1 | Wake event (interrupt) |
| snoop_i | input | 1 | Incoming snoop |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | RES_W+2 | Configuration value: enables and threshold |
| flush_req_o | output | 1 | Request to write back private caches |
| flush_done_i | input | 1 | Flush completed |
| clk_stop_o | output | 1 | Request to stop core clocks |
| clk_stopped_i | input | 1 | Clock gate status, high while stopped |
| save_req_o | output | 1 | Request to save architectural state |
| save_done_i | input | 1 | Save completed |
| pwr_cut_o | output | 1 | Request to remove core power |
| pwr_is_off_i | input | 1 | Power switch status, high while off |
| restore_req_o | output | 1 | Request to reload architectural state |
| restore_done_i | input | 1 | Restore completed |
| snoop_ack_o | output | 1 | Snoop serviced by the core |
| cstate_o | output | 2 | Resident level, 0 when active or in transit |
| busy_o | output | 1 | An entry or exit sequence is in progress |

## Verification
A wrong sequencer state shows at the ports within one cycle. The symptom is a handshake raised out of order, such as a clock stop or power cut without a completed flush or save, or a restore while power is still off. It can also be a resident level that does not match the merged, demoted target. A corrupted residency history shows only on the next deep request, as an unexpected demotion or a missing one. For that reason the stimulus chains many idle visits of random length against a tracked copy of the last residency. The abort paths are hit by pulsing wake while a flush or a power cut is still outstanding.

// File: rtl/idle_pkg.sv
package idle_pkg;

    typedef enum logic [1:0] {
        LV_RUN   = 2'd0,
        LV_HALT  = 2'd1,
        LV_CSTOP = 2'd2,
        LV_POFF  = 2'd3
    } idle_lvl_e;

    typedef enum logic [3:0] {
        S_ACT, S_HALT,
        S_FLUSH, S_GATE, S_CSTOP, S_UNGATE,
        S_SAVE, S_CUT, S_POFF, S_PWRUP, S_RESTORE
    } seq_st_e;

    typedef struct packed {
        logic to_halt;
        logic off_to_stop;
    } dem_en_t;

    function automatic idle_lvl_e lvl_min(idle_lvl_e a, idle_lvl_e b);
        return (a < b) ? a : b;
    endfunction

    function automatic idle_lvl_e demote_lvl(idle_lvl_e req, logic short_hist, dem_en_t en);
        if (short_hist && en.to_halt && (req == LV_CSTOP || req == LV_POFF))
            return LV_HALT;
        if (short_hist && en.off_to_stop && req == LV_POFF)
            return LV_CSTOP;
        return req;
    endfunction

    function automatic idle_lvl_e resident_lvl(seq_st_e s);
        case (s)
            S_HALT:  return LV_HALT;
            S_CSTOP: return LV_CSTOP;
            S_POFF:  return LV_POFF;
            default: return LV_RUN;
        endcase
    endfunction

    function automatic logic clocks_run(seq_st_e s);
        return (s == S_ACT) || (s == S_HALT) || (s == S_FLUSH) || (s == S_SAVE);
    endfunction

    function automatic logic in_entry(seq_st_e s);
        return (s == S_FLUSH) || (s == S_GATE) || (s == S_SAVE) || (s == S_CUT);
    endfunction

endpackage

// File: rtl/idle_thread_merge.sv
module idle_thread_merge
    import idle_pkg::*;
#(
    parameter int NUM_THREADS = 2
) (
    input  logic [2*NUM_THREADS-1:0] thr_req_i,
    output idle_lvl_e                target_o
);
    idle_lvl_e chain [NUM_THREADS+1];

    assign chain[0] = LV_POFF;

    for (genvar gi = 0; gi < NUM_THREADS; gi++) begin : g_thr
        assign chain[gi+1] = lvl_min(chain[gi], idle_lvl_e'(thr_req_i[2*gi +: 2]));
    end

    assign target_o = chain[NUM_THREADS];
endmodule

// File: rtl/idle_demote.sv
module idle_demote
    import idle_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cfg_we_i,
    input  logic [RES_W+1:0] cfg_wdata_i,
    input  logic             resident_i,
    input  idle_lvl_e        req_lvl_i,
    output idle_lvl_e        lvl_o
);
    localparam logic [RES_W-1:0] RES_MAX = '1;

    dem_en_t          en_q;
    logic [RES_W-1:0] thr_q;
    logic [RES_W-1:0] cnt_q;
    logic [RES_W-1:0] last_q;
    logic             resident_q;
    logic             short_hist;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q       <= '0;
            thr_q      <= '0;
            cnt_q      <= '0;
            last_q     <= RES_MAX;
            resident_q <= 1'b0;
        end else begin
            if (cfg_we_i) begin
                en_q.off_to_stop <= cfg_wdata_i[0];
                en_q.to_halt     <= cfg_wdata_i[1];
                thr_q            <= cfg_wdata_i[RES_W+1:2];
            end
            resident_q <= resident_i;
            if (resident_i)
                cnt_q <= (cnt_q == RES_MAX) ? cnt_q : cnt_q + 1'b1;
            else
                cnt_q <= '0;
            if (resident_q && !resident_i)
                last_q <= cnt_q;
        end
    end

    assign short_hist = (last_q < thr_q);
    assign lvl_o      = demote_lvl(req_lvl_i, short_hist, en_q);

    // R10: the counter stays pinned once saturated
    p_sat_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q == RES_MAX && resident_i) |=> (cnt_q == RES_MAX));

    // R10: history changes only when a visit ends
    p_last_stable_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !(resident_q && !resident_i) |=> $stable(last_q));

    // R13: with both enables clear, requests pass untouched
    p_no_demote_r13: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_q.off_to_stop && !en_q.to_halt) |-> (lvl_o == req_lvl_i));
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
    import idle_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  idle_lvl_e target_i,
    input  logic      wake_i,
    input  logic      snoop_i,
    input  logic      flush_done_i,
    input  logic      clk_stopped_i,
    input  logic      save_done_i,
    input  logic      pwr_is_off_i,
    input  logic      restore_done_i,
    output logic      flush_req_o,
    output logic      clk_stop_o,
    output logic      save_req_o,
    output logic      pwr_cut_o,
    output logic      restore_req_o,
    output logic      snoop_ack_o,
    output idle_lvl_e cstate_o,
    output logic      busy_o,
    output logic      resident_o
);
    seq_st_e state_q, state_d;
    logic    abort_q;
    logic    abort_now;
    logic    snoop_ack_q;

    assign abort_now = abort_q || wake_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ACT: begin
                if (!wake_i) begin
                    case (target_i)
                        LV_HALT:  state_d = S_HALT;
                        LV_CSTOP: state_d = S_FLUSH;
                        LV_POFF:  state_d = S_SAVE;
                        default:  state_d = S_ACT;
                    endcase
                end
            end
            S_HALT:    if (wake_i)          state_d = S_ACT;
            S_FLUSH:   if (flush_done_i)    state_d = abort_now ? S_ACT : S_GATE;
            S_GATE:    if (clk_stopped_i)   state_d = abort_now ? S_UNGATE : S_CSTOP;
            S_CSTOP:   if (wake_i)          state_d = S_UNGATE;
            S_UNGATE:  if (!clk_stopped_i)  state_d = S_ACT;
            S_SAVE:    if (save_done_i)     state_d = abort_now ? S_ACT : S_CUT;
            S_CUT:     if (pwr_is_off_i)    state_d = abort_now ? S_PWRUP : S_POFF;
            S_POFF:    if (wake_i)          state_d = S_PWRUP;
            S_PWRUP:   if (!pwr_is_off_i)   state_d = S_RESTORE;
            S_RESTORE: if (restore_done_i)  state_d = S_ACT;
            default:                        state_d = S_ACT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q     <= S_ACT;
            abort_q     <= 1'b0;
            snoop_ack_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            abort_q     <= in_entry(state_d) && abort_now && in_entry(state_q);
            snoop_ack_q <= snoop_i && clocks_run(state_q);
        end
    end

    assign flush_req_o   = (state_q == S_FLUSH);
    assign clk_stop_o    = (state_q == S_GATE) || (state_q == S_CSTOP);
    assign save_req_o    = (state_q == S_SAVE);
    assign pwr_cut_o     = (state_q == S_CUT) || (state_q == S_POFF);
    assign restore_req_o = (state_q == S_RESTORE);
    assign snoop_ack_o   = snoop_ack_q;
    assign cstate_o      = resident_lvl(state_q);
    assign resident_o    = (cstate_o != LV_RUN);
    assign busy_o        = !(state_q == S_ACT || resident_o);

    // R5: clocks stop only right after a completed flush
    p_gate_after_flush_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(clk_stop_o) |-> $past(flush_done_i));

    // R7: power is cut only right after a completed save
    p_cut_after_save_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pwr_cut_o) |-> $past(flush_done_i) == 1'b0 && $past(save_done_i));

    // R8: state reload starts only once power reads back on
    p_restore_after_power_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(restore_req_o) |-> !$past(pwr_is_off_i));

    // R4: a snoop in halt keeps the core halted
    p_halt_snoop_stay_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == S_HALT && snoop_i && !wake_i) |=> (state_q == S_HALT));

    // R4: a clock-stopped core ignores snoops
    p_cstop_no_snoop_wake_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == S_CSTOP && !wake_i) |=> (state_q == S_CSTOP) && !snoop_ack_o);

    // R9: an outstanding flush is never abandoned
    p_flush_completes_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == S_FLUSH && !flush_done_i) |=> (state_q == S_FLUSH));

    // R9: an aborted flush never leads to stopped clocks
    p_abort_no_gate_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (flush_req_o && flush_done_i && wake_i) |=> !clk_stop_o);

    // R2: at most one engine handshake is open at a time
    p_one_engine_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({flush_req_o, save_req_o, restore_req_o}));
endmodule

// File: rtl/idle_seq_ctrl.sv
module idle_seq_ctrl
    import idle_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int RES_W       = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [2*NUM_THREADS-1:0] thr_req_i,
    input  logic                     wake_i,
    input  logic                     snoop_i,
    input  logic                     cfg_we_i,
    input  logic [RES_W+1:0]         cfg_wdata_i,
    output logic                     flush_req_o,
    input  logic                     flush_done_i,
    output logic                     clk_stop_o,
    input  logic                     clk_stopped_i,
    output logic                     save_req_o,
    input  logic                     save_done_i,
    output logic                     pwr_cut_o,
    input  logic                     pwr_is_off_i,
    output logic                     restore_req_o,
    input  logic                     restore_done_i,
    output logic                     snoop_ack_o,
    output logic [1:0]               cstate_o,
    output logic                     busy_o
);
    idle_lvl_e merged_lvl;
    idle_lvl_e eff_lvl;
    idle_lvl_e cur_lvl;
    logic      resident;

    idle_thread_merge #(.NUM_THREADS(NUM_THREADS)) u_merge (
        .thr_req_i (thr_req_i),
        .target_o  (merged_lvl)
    );

    idle_demote #(.RES_W(RES_W)) u_demote (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata_i),
        .resident_i  (resident),
        .req_lvl_i   (merged_lvl),
        .lvl_o       (eff_lvl)
    );

    idle_seq_fsm u_fsm (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .target_i       (eff_lvl),
        .wake_i         (wake_i),
        .snoop_i        (snoop_i),
        .flush_done_i   (flush_done_i),
        .clk_stopped_i  (clk_stopped_i),
        .save_done_i    (save_done_i),
        .pwr_is_off_i   (pwr_is_off_i),
        .restore_done_i (restore_done_i),
        .flush_req_o    (flush_req_o),
        .clk_stop_o     (clk_stop_o),
        .save_req_o     (save_req_o),
        .pwr_cut_o      (pwr_cut_o),
        .restore_req_o  (restore_req_o),
        .snoop_ack_o    (snoop_ack_o),
        .cstate_o       (cur_lvl),
        .busy_o         (busy_o),
        .resident_o     (resident)
    );

    assign cstate_o = cur_lvl;
endmodule

// File: tb/sim_idle_seq_ctrl.sv
module sim_idle_seq_ctrl;
    localparam int NT = 2;
    localparam int RW = 8;
    localparam int RMAX = (1 << RW) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_i;
    logic [2*NT-1:0] thr_req_i;
    logic wake_i, snoop_i, cfg_we_i;
    logic [RW+1:0] cfg_wdata_i;
    logic flush_req_o, flush_done_i, clk_stop_o, clk_stopped_i;
    logic save_req_o, save_done_i, pwr_cut_o, pwr_is_off_i;
    logic restore_req_o, restore_done_i, snoop_ack_o, busy_o;
    logic [1:0] cstate_o;

    idle_seq_ctrl #(.NUM_THREADS(NT), .RES_W(RW)) u0 (
        .clk_i(clk), .rst_i(rst_i), .thr_req_i(thr_req_i), .wake_i(wake_i),
        .snoop_i(snoop_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
        .flush_req_o(flush_req_o), .flush_done_i(flush_done_i),
        .clk_stop_o(clk_stop_o), .clk_stopped_i(clk_stopped_i),
        .save_req_o(save_req_o), .save_done_i(save_done_i),
        .pwr_cut_o(pwr_cut_o), .pwr_is_off_i(pwr_is_off_i),
        .restore_req_o(restore_req_o), .restore_done_i(restore_done_i),
        .snoop_ack_o(snoop_ack_o), .cstate_o(cstate_o), .busy_o(busy_o)
    );

    int vectors = 0;
    int fails = 0;
    bit finished = 0;
    bit flushed, saved, restored, gate_seen, poff_seen;
    bit m_en_stop = 0, m_en_halt = 0;
    int m_thr = 0;
    int m_last = RMAX;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_lvl(input int rm);
        bit short_h = (m_last < m_thr);
        if (short_h && m_en_halt && rm >= 2) return 1;
        if (short_h && m_en_stop && rm == 3) return 2;
        return rm;
    endfunction

    // engine models
    initial begin
        flush_done_i = 0;
        forever begin
            @(negedge clk);
            if (flush_req_o) begin
                repeat ($urandom_range(4, 1)) @(negedge clk);
                flush_done_i = 1; flushed = 1;
                @(negedge clk);
                flush_done_i = 0;
            end
        end
    end
    initial begin
        save_done_i = 0;
        forever begin
            @(negedge clk);
            if (save_req_o) begin
                repeat ($urandom_range(4, 1)) @(negedge clk);
                save_done_i = 1; saved = 1;
                @(negedge clk);
                save_done_i = 0;
            end
        end
    end
    initial begin
        restore_done_i = 0;
        forever begin
            @(negedge clk);
            if (restore_req_o) begin
                repeat ($urandom_range(3, 1)) @(negedge clk);
                chk(!pwr_is_off_i, "R8 restore only with power on", int'(pwr_is_off_i), 0);
                restore_done_i = 1; restored = 1;
                @(negedge clk);
                restore_done_i = 0;
            end
        end
    end
    initial begin
        clk_stopped_i = 0;
        forever begin
            @(negedge clk);
            if (clk_stop_o != clk_stopped_i) begin
                repeat ($urandom_range(3, 1)) @(negedge clk);
                clk_stopped_i = clk_stop_o;
            end
        end
    end
    initial begin
        pwr_is_off_i = 0;
        forever begin
            @(negedge clk);
            if (pwr_cut_o != pwr_is_off_i) begin
                repeat ($urandom_range(4, 2)) @(negedge clk);
                pwr_is_off_i = pwr_cut_o;
            end
        end
    end

    // ordering monitor
    initial begin
        bit cs_prev = 0, pc_prev = 0;
        forever begin
            @(negedge clk);
            if (!rst_i) begin
                if (clk_stop_o && !cs_prev)
                    chk(flushed, "R5 clocks stopped before flush done", int'(flushed), 1);
                if (pwr_cut_o && !pc_prev)
                    chk(saved, "R7 power cut before save done", int'(saved), 1);
                if (clk_stop_o) gate_seen = 1;
                if (cstate_o == 2'd3) poff_seen = 1;
            end
            cs_prev = clk_stop_o;
            pc_prev = pwr_cut_o;
        end
    end

    task automatic clear_flags();
        flushed = 0; saved = 0; restored = 0; gate_seen = 0; poff_seen = 0;
    endtask

    task automatic wait_idle(input string tag);
        int g = 0;
        while (!(cstate_o == 2'd0 && !busy_o) && g < 400) begin
            @(negedge clk);
            g++;
        end
        chk(cstate_o == 2'd0 && !busy_o, tag, int'(cstate_o), 0);
    endtask

    task automatic write_cfg(input bit en_stop, input bit en_halt, input int thr);
        cfg_wdata_i = {thr[RW-1:0], en_halt, en_stop};
        cfg_we_i = 1;
        @(negedge clk);
        cfg_we_i = 0;
        m_en_stop = en_stop; m_en_halt = en_halt; m_thr = thr;
    endtask

    task automatic episode(input logic [1:0] t0, input logic [1:0] t1, input int hold);
        int rm, ex, cnt, g;
        rm = (t0 < t1) ? int'(t0) : int'(t1);
        if (rm == 0) begin
            thr_req_i = {t1, t0};
            repeat (6) @(negedge clk);
            chk(cstate_o == 0 && !busy_o && !flush_req_o && !save_req_o,
                "R2 running thread keeps core active", int'(cstate_o), 0);
            thr_req_i = '0;
            @(negedge clk);
            return;
        end
        ex = exp_lvl(rm);
        clear_flags();
        thr_req_i = {t1, t0};
        g = 0;
        while (cstate_o == 2'd0 && g < 300) begin
            @(negedge clk);
            g++;
        end
        if (ex == 1 && rm > 1)
            chk(int'(cstate_o) == ex, "R12 demotion to halt", int'(cstate_o), ex);
        else if (ex != rm)
            chk(int'(cstate_o) == ex, "R11 power-off demoted to clock-stop", int'(cstate_o), ex);
        else
            chk(int'(cstate_o) == ex, "R2 shallowest thread target", int'(cstate_o), ex);
        if (ex == 1)
            chk(!flushed && !saved, "R3 halt without handshakes", int'(flushed) + int'(saved), 0);
        else if (ex == 2)
            chk(flushed && !saved, "R5 flush before clock stop", int'(flushed), 1);
        else
            chk(saved && !flushed, "R7 save before power cut", int'(saved), 1);
        cnt = 1;
        for (int i = 1; i < hold; i++) begin
            if (i == 1) snoop_i = 1;
            @(negedge clk);
            if (i == 1) begin
                chk(snoop_ack_o == (ex == 1), "R4 snoop acknowledge per level", int'(snoop_ack_o), int'(ex == 1));
                chk(int'(cstate_o) == ex, "R4 snoop keeps level", int'(cstate_o), ex);
                snoop_i = 0;
            end
            if (cstate_o != 2'd0) cnt++;
        end
        wake_i = 1; thr_req_i = '0;
        @(negedge clk);
        wake_i = 0;
        m_last = (cnt > RMAX) ? RMAX : cnt;
        if (ex == 1) begin
            chk(cstate_o == 0 && !busy_o, "R3 wake leaves halt next clock", int'(cstate_o), 0);
        end else if (ex == 2) begin
            wait_idle("R6 clock-stop exit reaches active");
            chk(!clk_stop_o && !clk_stopped_i, "R6 clocks running after exit", int'(clk_stopped_i), 0);
        end else begin
            wait_idle("R8 power-off exit reaches active");
            chk(restored && !pwr_is_off_i, "R8 state reloaded after power-up", int'(restored), 1);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7101));
        rst_i = 1; thr_req_i = '0; wake_i = 0; snoop_i = 0;
        cfg_we_i = 0; cfg_wdata_i = '0;
        clear_flags();
        repeat (4) @(negedge clk);
        rst_i = 0;
        @(negedge clk);
        chk(cstate_o == 0 && !busy_o, "R1 reset state active", int'(cstate_o), 0);
        chk(!flush_req_o && !save_req_o && !restore_req_o && !clk_stop_o && !pwr_cut_o && !snoop_ack_o,
            "R1 reset outputs low",
            int'({flush_req_o, save_req_o, restore_req_o, clk_stop_o, pwr_cut_o, snoop_ack_o}), 0);

        // R13: demotion off after reset even with a short history
        episode(2'd3, 2'd3, 2);
        episode(2'd3, 2'd3, 4);
        // R13: threshold loaded but enables clear
        write_cfg(0, 0, 200);
        episode(2'd3, 2'd3, 5);
        // R2: one thread running
        episode(2'd1, 2'd0, 1);
        // R11
        write_cfg(1, 0, 200);
        episode(2'd3, 2'd3, 6);
        episode(2'd2, 2'd3, 6);
        // R12 with priority
        write_cfg(1, 1, 200);
        episode(2'd3, 2'd2, 4);
        // R10: saturation then threshold at maximum
        write_cfg(0, 0, 0);
        episode(2'd3, 2'd3, 300);
        write_cfg(1, 1, RMAX);
        episode(2'd3, 2'd3, 5);
        episode(2'd1, 2'd3, 5);
        episode(2'd2, 2'd2, 5);

        // R9: wake during flush
        write_cfg(0, 0, 0);
        clear_flags();
        thr_req_i = {2'd2, 2'd2};
        while (!flush_req_o) @(negedge clk);
        wake_i = 1; thr_req_i = '0;
        @(negedge clk);
        wake_i = 0;
        wait_idle("R9 aborted flush returns active");
        chk(!gate_seen && flushed, "R9 no clock stop after aborted flush", int'(gate_seen), 0);
        repeat (3) @(negedge clk);

        // R9: wake while power is being cut
        clear_flags();
        thr_req_i = {2'd3, 2'd3};
        while (!(pwr_cut_o && !pwr_is_off_i)) @(negedge clk);
        wake_i = 1; thr_req_i = '0;
        @(negedge clk);
        wake_i = 0;
        wait_idle("R9 aborted power cut returns active");
        chk(restored && !poff_seen, "R9 restore without residency", int'(poff_seen), 0);
        repeat (3) @(negedge clk);

        // random mix
        for (int k = 0; k < 70; k++) begin
            if (k % 8 == 0)
                write_cfg(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), $urandom_range(40, 0));
            episode(2'($urandom_range(3, 0)), 2'($urandom_range(3, 0)), $urandom_range(40, 1));
        end
        finish_run();
    end
endmodule